// File: doc/BRIEF.md
# Dithered Phase-Offset Quadrature NCO

This block is a numerically controlled oscillator that feeds a digital mixer with a cosine and a sine sample on every clock. A wide phase accumulator advances by a programmable frequency word on each cycle. A programmable phase offset is added to the phase, and so is an optional small pseudo-random dither term. The top bits of the result then address a quarter-wave amplitude table. The dither shifts the truncation error of the table address from cycle to cycle, so that it spreads the spurs that truncation would otherwise produce.

The amplitude table is computed at elaboration from a closed-form formula and is then mirrored across the four quadrants. A synchronous clear strobe sets the accumulator back to phase zero. This lets several oscillators be aligned, or a burst start at a known phase.

Top module: `dith_nco`

## Requirements
- R1: While rst_ni is low, cos_o and sin_o are 0, the accumulator is 0 and the dither LFSR holds the seed 16'hACE1.
- R2: On every clock edge where clr_i is low, the 48-bit accumulator becomes (accumulator + freq_i) mod 2^48. A new freq_i is used at the first edge where it is present.
- R3: At edge n the phase P is computed from the accumulator value, ofs_i, dith_en_i and the LFSR state present just before edge n, as P = acc + (ofs_i << 32) + D, mod 2^48. The cos_o/sin_o pair derived from P appears after edge n+2.
- R4: The 16-bit offset ofs_i is aligned to phase bits [47:32], so 16'h4000 is a quarter turn.
- R5: When dith_en_i is low, D is 0. With freq_i at 0 and ofs_i and dith_en_i held, the outputs are then constant.
- R6: When dith_en_i is high, D = LFSR[6:0] << 31, which places the 7 dither bits just below the table address. The LFSR is 16 bits and shifts on every clock after reset as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}, whatever the enable.
- R7: The table address is A = P[47:38]. The quadrant is q = A[9:8] and the index is k = A[7:0]. With T[] the quarter table and ~k the bitwise inverse: q=0 gives cos=T[~k], sin=T[k]. q=1 gives cos=-T[k], sin=T[~k]. q=2 gives cos=-T[~k], sin=-T[k]. q=3 gives cos=T[k], sin=-T[~k].
- R8: When clr_i is high at an edge, the accumulator becomes 0 after that edge, and freq_i is not added.
- R9: T[k] = floor(524287*sin(pi*(2k+1)/1024) + 0.5) for k = 0..255. The outputs are 20-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | 48 | Frequency word added to the accumulator each cycle |
| ofs_i | input | 16 | Phase offset, aligned to the top of the phase |
| dith_en_i | input | 1 | Enables the pseudo-random dither term |
| clr_i | input | 1 | Synchronous accumulator clear strobe |
| cos_o | output | 20 | Signed cosine sample |
| sin_o | output | 20 | Signed sine sample |

## Verification
A zero frequency word combined with each quarter-turn offset pins the outputs to known table entries. This separates quadrant sign and mirroring faults from accumulator faults. A slow sweep at one address step per cycle visits every table entry in all four quadrants, and a large wrapping word exposes carry and modulo errors. A run with dither on, set against the same run with dither off, shows whether the LFSR bits are added in the right sequence and at the right position. Clear pulses and mid-run changes of the frequency word pin down the exact cycle in which each input takes effect.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    Q_0 = 2'd0,
    Q_1 = 2'd1,
    Q_2 = 2'd2,
    Q_3 = 2'd3
  } quad_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_q + freq_i;
  end

  assign acc_o = acc_q;

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (acc_q == '0));
endmodule

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
  parameter int          DITH_W = 7,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [DITH_W-1:0] dith_o
);
  logic [15:0] lfsr_q;
  logic        fb;

  assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  // free-running so the sequence position does not depend on enable history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[14:0], fb};
  end

  assign dith_o = en_i ? lfsr_q[DITH_W-1:0] : '0;

  p_lfsr_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  p_dith_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (dith_o == '0));
endmodule

// File: rtl/nco_phase_sum.sv
module nco_phase_sum #(
  parameter int ACC_W  = 48,
  parameter int OFS_W  = 16,
  parameter int DITH_W = 7,
  parameter int TAB_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DITH_W-1:0] dith_i,
  output logic [TAB_W-1:0]  addr_o
);
  localparam int SH_OFS = ACC_W - OFS_W;
  localparam int SH_DIT = ACC_W - TAB_W - DITH_W;

  logic [ACC_W-1:0] ofs_ext, dith_ext, sum;
  logic [TAB_W-1:0] addr_q;

  assign ofs_ext  = {ofs_i, {SH_OFS{1'b0}}};
  assign dith_ext = ACC_W'(dith_i) << SH_DIT;
  assign sum      = acc_i + ofs_ext + dith_ext;

  // only the table address bits are kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= sum[ACC_W-1 -: TAB_W];
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom
  import nco_pkg::*;
#(
  parameter int TAB_W = 10,
  parameter int OUT_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TAB_W-1:0]        addr_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam int IDX_W = TAB_W - 2;
  localparam int QN    = 1 << IDX_W;
  localparam int MAG_W = OUT_W - 1;
  localparam int AMP   = (1 << MAG_W) - 1;

  function automatic logic [MAG_W-1:0] tab_val(input int k);
    real ang, v;
    ang = 3.14159265358979323846 * (2.0 * k + 1.0) / (4.0 * QN);
    v   = $sin(ang) * AMP + 0.5;
    return MAG_W'($rtoi(v));
  endfunction

  logic [MAG_W-1:0] rom [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign rom[g] = tab_val(g);
  end

  logic [IDX_W-1:0] idx;
  quad_e            quad;
  logic [MAG_W-1:0] mag_f_q, mag_r_q;
  quad_e            quad_q;

  assign idx  = addr_i[IDX_W-1:0];
  assign quad = quad_e'(addr_i[TAB_W-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_f_q <= '0;
      mag_r_q <= '0;
      quad_q  <= Q_0;
    end else begin
      mag_f_q <= rom[idx];
      mag_r_q <= rom[~idx];
      quad_q  <= quad;
    end
  end

  logic signed [OUT_W-1:0] pf, pr, nf, nr, cos_d, sin_d;
  assign pf = $signed({1'b0, mag_f_q});
  assign pr = $signed({1'b0, mag_r_q});
  assign nf = -pf;
  assign nr = -pr;

  always_comb begin
    unique case (quad_q)
      Q_0: begin cos_d = pr; sin_d = pf; end
      Q_1: begin cos_d = nf; sin_d = pr; end
      Q_2: begin cos_d = nr; sin_d = nf; end
      default: begin cos_d = pf; sin_d = nr; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      cos_o <= cos_d;
      sin_o <= sin_d;
    end
  end

  p_quad_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(quad_q) == Q_0) |-> (!cos_o[OUT_W-1] && !sin_o[OUT_W-1]));
  p_quad2_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(quad_q) == Q_2 && $past(mag_f_q) != '0 && $past(mag_r_q) != '0)
      |-> (cos_o[OUT_W-1] && sin_o[OUT_W-1]));
  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_o != {1'b1, {(OUT_W-1){1'b0}}}) && (sin_o != {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: rtl/dith_nco.sv
module dith_nco #(
  parameter int ACC_W  = 48,
  parameter int OFS_W  = 16,
  parameter int DITH_W = 7,
  parameter int TAB_W  = 10,
  parameter int OUT_W  = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ACC_W-1:0]        freq_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  logic                    dith_en_i,
  input  logic                    clr_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  logic [ACC_W-1:0]  acc;
  logic [DITH_W-1:0] dith;
  logic [TAB_W-1:0]  addr;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .freq_i, .clr_i, .acc_o(acc)
  );

  nco_dither_lfsr #(.DITH_W(DITH_W)) u_lfsr (
    .clk_i, .rst_ni, .en_i(dith_en_i), .dith_o(dith)
  );

  nco_phase_sum #(.ACC_W(ACC_W), .OFS_W(OFS_W), .DITH_W(DITH_W), .TAB_W(TAB_W)) u_sum (
    .clk_i, .rst_ni, .acc_i(acc), .ofs_i, .dith_i(dith), .addr_o(addr)
  );

  nco_sincos_rom #(.TAB_W(TAB_W), .OUT_W(OUT_W)) u_rom (
    .clk_i, .rst_ni, .addr_i(addr), .cos_o, .sin_o
  );

  // quiet-window counter for the stability check
  logic [OFS_W-1:0] ofs_prev;
  logic [2:0]       quiet_cnt;
  logic             quiet;
  assign quiet = (freq_i == '0) && !dith_en_i && !clr_i && (ofs_i == ofs_prev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_prev  <= '0;
      quiet_cnt <= '0;
    end else begin
      ofs_prev  <= ofs_i;
      quiet_cnt <= !quiet ? 3'd0 : (quiet_cnt == 3'd7) ? 3'd7 : quiet_cnt + 3'd1;
    end
  end

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_cnt >= 3'd5) |-> ($stable(cos_o) && $stable(sin_o)));
endmodule

// File: tb/dith_nco_test.sv
module dith_nco_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [47:0] freq = '0;
  logic [15:0] ofs = '0;
  logic den = 1'b0, clr = 1'b0;
  logic signed [19:0] cos_w, sin_w;
  int n_tests = 0, n_fail = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  dith_nco uut (
    .clk_i(clk), .rst_ni(rst_n), .freq_i(freq), .ofs_i(ofs),
    .dith_en_i(den), .clr_i(clr), .cos_o(cos_w), .sin_o(sin_w)
  );

  function automatic int tab(input int k);
    real a;
    a = 3.14159265358979323846 * (2.0 * k + 1.0) / 1024.0;
    return $rtoi($floor(524287.0 * $sin(a) + 0.5));
  endfunction

  task automatic expect_pair(input logic [9:0] a, output int c, output int s);
    int k, kr;
    k = int'(a[7:0]);
    kr = 255 - k;
    case (a[9:8])
      2'd0: begin c = tab(kr);  s = tab(k);   end
      2'd1: begin c = -tab(k);  s = tab(kr);  end
      2'd2: begin c = -tab(kr); s = -tab(k);  end
      default: begin c = tab(k); s = -tab(kr); end
    endcase
  endtask

  task automatic check(input string tag, input int act_c, input int act_s, input int exp_c, input int exp_s);
    n_tests++;
    if (act_c != exp_c || act_s != exp_s) begin
      n_fail++;
      $display("FAIL %s: cos/sin actual %0d/%0d expected %0d/%0d", tag, act_c, act_s, exp_c, exp_s);
    end
  endtask

  // scoreboard model
  logic [47:0] m_acc;
  logic [15:0] m_lfsr;
  int qc[$], qs[$];
  string qt[$];

  always @(posedge clk) begin
    logic [47:0] p;
    int ec, es;
    if (!rst_n) begin
      m_acc = '0;
      m_lfsr = 16'hACE1;
      qc.delete(); qs.delete(); qt.delete();
    end else begin
      p = m_acc + {ofs, 32'b0} + (den ? (48'(m_lfsr[6:0]) << 31) : 48'd0);
      expect_pair(p[47:38], ec, es);
      qc.push_back(ec); qs.push_back(es); qt.push_back(cur_tag);
      m_acc = clr ? 48'd0 : m_acc + freq;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && qc.size() == 3) begin
      int ec, es;
      string t;
      ec = qc.pop_front(); es = qs.pop_front(); t = qt.pop_front();
      check(t, int'(cos_w), int'(sin_w), ec, es);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic main_seq();
    int c, s;
    @(negedge clk);
    check("R1 reset outputs", int'(cos_w), int'(sin_w), 0, 0);
    run(2);
    rst_n = 1'b1;
    // zero phase
    cur_tag = "R5 zero phase";
    run(8);
    check("R9 T[255]/T[0] at phase 0", int'(cos_w), int'(sin_w), tab(255), tab(0));
    // quarter-turn offsets
    cur_tag = "R4 ofs 4000";
    ofs = 16'h4000; run(6);
    check("R7 quadrant 1", int'(cos_w), int'(sin_w), -tab(0), tab(255));
    cur_tag = "R4 ofs 8000";
    ofs = 16'h8000; run(6);
    check("R7 quadrant 2", int'(cos_w), int'(sin_w), -tab(255), -tab(0));
    cur_tag = "R4 ofs C0C0";
    ofs = 16'hC0C0; run(6);
    expect_pair(10'h303, c, s);
    check("R7 quadrant 3 idx 3", int'(cos_w), int'(sin_w), c, s);
    // one address step per cycle, full sweep
    cur_tag = "R2 sweep";
    ofs = 16'h0000; clr = 1'b1; run(1); clr = 1'b0;
    freq = 48'h0040_0000_0000; run(1100);
    // latency after clear with zero freq
    cur_tag = "R3 clear latency";
    freq = 48'd0; clr = 1'b1; run(1); clr = 1'b0; run(6);
    check("R8 clear to phase 0", int'(cos_w), int'(sin_w), tab(255), tab(0));
    // wrapping word
    cur_tag = "R2 wrap";
    freq = 48'hF000_0000_1234; run(300);
    cur_tag = "R2 freq change";
    freq = 48'h0123_4567_89AB; run(200);
    // dither
    cur_tag = "R6 dither static";
    freq = 48'd0; clr = 1'b1; run(1); clr = 1'b0;
    ofs = 16'h0001; den = 1'b1; run(400);
    cur_tag = "R6 dither moving";
    freq = 48'h0001_2345_6789; run(400);
    cur_tag = "R5 dither off";
    den = 1'b0; run(200);
    cur_tag = "R8 clear pulses";
    repeat (5) begin
      clr = 1'b1; run(1); clr = 1'b0; run(13);
    end
    cur_tag = "R3 drain";
    freq = 48'd0; run(5);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule